// File: doc/BRIEF.md
# Byte-Serial SPI Controller with Master Demotion

The block is a single-byte SPI engine that works either as the bus master or as a slave. Software controls it through three registers: control, status and data. In master mode the block generates SCK from the system clock and shifts a byte out on MOSI while it shifts a byte in on MISO. In slave mode it follows an external SCK and an external select line. Transfers use mode 0, MSB first. A bit is sampled on the rising SCK edge and the next bit is presented on the falling edge. The block also produces an output enable for each pin, which the pad ring uses to set pin directions.

The transmit path has one buffer. Once a transfer has started, a second write to the data register is dropped. The receive path has two buffers. Each finished byte is copied into a read buffer, and that buffer is overwritten when the next byte finishes.

A master whose select line is configured as an input watches that line for another master taking the bus. If the line goes low, the block clears its own master bit, releases SCK and MOSI, and raises the completion flag. Software must set the master bit again to return to master mode.

Top module: `spi_ctrl`

## Requirements

- R1: After reset:
  - the control register and the status register read 0;
  - every pin output enable is 0;
  - `irq` is 0.
- R2: Register layout and the master transfer:
  - Addresses: `reg_sel` 0 is control, 1 is status and 2 is data. Address 3 reads 0.
  - Control bits: bit 7 is enable, bit 6 is master, bit 5 is interrupt enable, and bits 1:0 are the divider code. Status bit 7 is the completion flag.
  - In master mode, a write to the data register starts an 8-bit exchange. MOSI carries the written byte MSB first, and MISO is sampled on each rising SCK edge.
  - After the eighth bit, the received byte is readable at the data address and the completion flag is set.
- R3: The master SCK half period, in system clocks, is 2, 8, 32 or 64 for divider codes 0, 1, 2 and 3 (a full period of 4, 16, 64 or 128). SCK rests low between transfers.
- R4: A write to the data register while a master transfer is in progress has no effect:
  - the byte on MOSI is the byte that was written first;
  - exactly 8 SCK rising edges are produced.
- R5: Each finished byte overwrites the read buffer. If two bytes finish without a read in between, the data address returns the second byte.
- R6: The completion flag is cleared by a status read that sees the flag set, followed by an access to the data register. A data read without that earlier status read leaves the flag set.
- R7: `irq` is high exactly when all three of these are set: the completion flag, the interrupt-enable bit and the `gie` input.
- R8: Pin directions while enabled as master:
  - `miso_oe` is 0.
  - `mosi_oe`, `sck_oe` and `ss_oe` follow `dir_mosi`, `dir_sck` and `dir_ss`.
  - With `dir_ss`=1, a low `ss_i` has no effect: the master bit stays set and the flag stays clear.
- R9: Mode fault. While enabled as master with `dir_ss`=0, a low `ss_i` (seen within 4 clocks) causes all of the following:
  - the master bit clears;
  - the completion flag sets;
  - `sck_oe` and `mosi_oe` drop to 0.
  
  The master bit stays 0 after `ss_i` returns high, and is set again only by a control write.
- R10: Slave mode:
  - While `ss_i` is low, `miso_oe` equals `dir_miso`.
  - While `ss_i` is high, every output enable is 0 and SCK edges are ignored: no flag is set and the read buffer is unchanged.
  - Raising `ss_i` in the middle of a byte discards the bits received so far.
- R11: In slave mode, a byte written to the data register while no byte is in progress is shifted out on MISO MSB first. At the same time a byte is received from MOSI, and the completion flag sets after its eighth bit.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the flag-clear sequence) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| dir_mosi | input | 1 | User direction bit for MOSI, 1 means output |
| dir_miso | input | 1 | User direction bit for MISO |
| dir_sck | input | 1 | User direction bit for SCK |
| dir_ss | input | 1 | User direction bit for SS |
| sck_i | input | 1 | SCK pin input |
| sck_o | output | 1 | SCK pin output value |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output value |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output value |
| miso_oe | output | 1 | MISO output enable |
| ss_i | input | 1 | SS pin input |
| ss_oe | output | 1 | SS output enable (the SS output value is general-purpose and lies outside the block) |

## Verification

A fault in the shared shift counter shows up at the ports within the same byte:

- a miscounted counter sends the wrong byte on MOSI or MISO;
- it sets the flag early or late;
- it produces a ninth SCK edge.

A master bit that fails to clear leaves `sck_oe` and `mosi_oe` high within a few clocks of SS going low. A wrong flag or arming state changes the status value read back on the next register access. A slave counter that survives a rise of SS corrupts the next full byte read at the data address.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int REG_W  = 8;
  localparam int DIV_W  = 2;
  localparam int HALF_W = 7;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  localparam int CTL_EN   = 7;
  localparam int CTL_MST  = 6;
  localparam int CTL_IE   = 5;
  localparam int STA_DONE = 7;

  // SCK half period in system clocks for each divider code
  function automatic logic [HALF_W-1:0] half_period(input logic [DIV_W-1:0] code);
    case (code)
      2'd0:    return HALF_W'(2);
      2'd1:    return HALF_W'(8);
      2'd2:    return HALF_W'(32);
      default: return HALF_W'(64);
    endcase
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen
  import spi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  output logic             sck,
  output logic             rise,
  output logic             fall
);
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              sck_q, sck_d;
  logic              tick;

  assign tick = run && (cnt_q == half_period(div_sel) - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck  = sck_q;
  assign rise = tick & ~sck_q;
  assign fall = tick & sck_q;
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  output logic              dout,
  output logic              done,
  output logic              idle,
  output logic [DATA_W-1:0] rx_val
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sr_q, sr_d;
  logic              cap_q, cap_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              last;

  assign last = (cnt_q == CNT_W'(DATA_W - 1));
  assign done = fall && !clr && !load && last;

  always_comb begin
    sr_d  = sr_q;
    cap_d = cap_q;
    cnt_d = cnt_q;
    if (load) begin
      sr_d  = load_val;
      cnt_d = '0;
    end else if (clr) begin
      cnt_d = '0;
    end else if (rise) begin
      cap_d = din;
    end else if (fall) begin
      sr_d  = {sr_q[DATA_W-2:0], cap_q};
      cnt_d = last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cap_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cap_q <= cap_d;
      cnt_q <= cnt_d;
    end
  end

  assign dout   = sr_q[DATA_W-1];
  assign idle   = (cnt_q == '0);
  assign rx_val = {sr_q[DATA_W-2:0], cap_q};
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             gie,
  output logic             irq,
  input  logic             dir_mosi,
  input  logic             dir_miso,
  input  logic             dir_sck,
  input  logic             dir_ss,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             mosi_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             miso_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             ss_i,
  output logic             ss_oe
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  // pin synchronizers and slave edge detect
  logic ss_s, sck_s, sck_q;
  spi_sync #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_ni), .d({ss_i, sck_i}), .q({ss_s, sck_s})
  );
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s;
  end

  logic             en_q, en_d, mst_q, mst_d, ie_q, ie_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             flag_q, flag_d, armed_q, armed_d, busy_q, busy_d;
  logic [REG_W-1:0] rx_q, rx_d;

  logic master_act, slave_sel, fault;
  logic m_sck, m_rise, m_fall, s_rise, s_fall;
  logic sh_rise, sh_fall, sh_din, sh_clr, sh_dout, sh_done, sh_idle;
  logic [REG_W-1:0] sh_rx;
  logic wr_ctrl, wr_data, rd_stat, acc_data, data_ok, load;
  logic unused_wbits;

  assign master_act = en_q & mst_q;
  assign slave_sel  = en_q & ~mst_q & ~ss_s;
  assign fault      = master_act & ~dir_ss & ~ss_s;
  assign s_rise     = slave_sel & sck_s & ~sck_q;
  assign s_fall     = slave_sel & ~sck_s & sck_q;

  assign wr_ctrl  = reg_wr && (reg_sel == ADDR_CTRL);
  assign wr_data  = reg_wr && (reg_sel == ADDR_DATA);
  assign rd_stat  = reg_rd && (reg_sel == ADDR_STAT);
  assign acc_data = (reg_wr || reg_rd) && (reg_sel == ADDR_DATA);
  assign data_ok  = en_q & (master_act ? ~busy_q : sh_idle);
  assign load     = wr_data & data_ok;
  assign unused_wbits = ^reg_wdata[4:2];

  assign sh_rise = master_act ? m_rise : s_rise;
  assign sh_fall = master_act ? m_fall : s_fall;
  assign sh_din  = master_act ? miso_i : mosi_i;
  assign sh_clr  = ~en_q | fault | (~master_act & ss_s);

  spi_clkgen u_clkgen (
    .clk(clk), .rst_n(rst_ni), .run(busy_q & master_act), .div_sel(div_q),
    .sck(m_sck), .rise(m_rise), .fall(m_fall)
  );

  spi_shift #(.DATA_W(REG_W)) u_shift (
    .clk(clk), .rst_n(rst_ni), .clr(sh_clr), .load(load), .load_val(reg_wdata),
    .rise(sh_rise), .fall(sh_fall), .din(sh_din), .dout(sh_dout),
    .done(sh_done), .idle(sh_idle), .rx_val(sh_rx)
  );

  always_comb begin
    en_d    = en_q;
    mst_d   = mst_q;
    ie_d    = ie_q;
    div_d   = div_q;
    busy_d  = busy_q;
    flag_d  = flag_q;
    armed_d = armed_q;
    rx_d    = rx_q;
    if (wr_ctrl) begin
      en_d  = reg_wdata[CTL_EN];
      mst_d = reg_wdata[CTL_MST];
      ie_d  = reg_wdata[CTL_IE];
      div_d = reg_wdata[DIV_W-1:0];
    end
    if (fault) mst_d = 1'b0;
    if (load && master_act) busy_d = 1'b1;
    if (sh_done || fault || !master_act) busy_d = 1'b0;
    if (rd_stat && flag_q) armed_d = 1'b1;
    if (armed_q && acc_data) begin
      flag_d  = 1'b0;
      armed_d = 1'b0;
    end
    if (sh_done || fault) flag_d = 1'b1;
    if (sh_done) rx_d = sh_rx;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      mst_q   <= 1'b0;
      ie_q    <= 1'b0;
      div_q   <= '0;
      busy_q  <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      rx_q    <= '0;
    end else begin
      en_q    <= en_d;
      mst_q   <= mst_d;
      ie_q    <= ie_d;
      div_q   <= div_d;
      busy_q  <= busy_d;
      flag_q  <= flag_d;
      armed_q <= armed_d;
      rx_q    <= rx_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr_e'(reg_sel))
      ADDR_CTRL: begin
        reg_rdata[CTL_EN]      = en_q;
        reg_rdata[CTL_MST]     = mst_q;
        reg_rdata[CTL_IE]      = ie_q;
        reg_rdata[DIV_W-1:0]   = div_q;
      end
      ADDR_STAT: reg_rdata[STA_DONE] = flag_q;
      ADDR_DATA: reg_rdata = rx_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq     = flag_q & ie_q & gie;
  assign sck_o   = m_sck;
  assign mosi_o  = sh_dout;
  assign miso_o  = sh_dout;
  assign sck_oe  = master_act & dir_sck;
  assign mosi_oe = master_act & dir_mosi;
  assign ss_oe   = master_act & dir_ss;
  assign miso_oe = slave_sel & dir_miso;
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic en_q,
  input logic mst_q,
  input logic ie_q,
  input logic flag_q,
  input logic busy_q,
  input logic dir_ss,
  input logic ss_s,
  input logic gie,
  input logic irq,
  input logic sck_oe,
  input logic mosi_oe,
  input logic miso_oe,
  input logic ss_oe,
  input logic mosi_o,
  input logic sh_done,
  input logic sh_fall,
  input logic wr_data
);
  AST_FLAG_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    sh_done |=> flag_q); // R2

  AST_TX_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_data && !sh_fall) |=> $stable(mosi_o)); // R4

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gie && ie_q && flag_q)); // R7

  AST_MASTER_MISO_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mst_q) |-> !miso_oe); // R8

  AST_FAULT_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mst_q && !dir_ss && !ss_s) |=> (!mst_q && flag_q && !sck_oe && !mosi_oe)); // R9

  AST_SLAVE_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !mst_q && ss_s) |-> !(miso_oe || sck_oe || mosi_oe || ss_oe)); // R10
endmodule

bind spi_ctrl spi_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_ni), .en_q(en_q), .mst_q(mst_q), .ie_q(ie_q),
  .flag_q(flag_q), .busy_q(busy_q), .dir_ss(dir_ss), .ss_s(ss_s), .gie(gie),
  .irq(irq), .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe),
  .ss_oe(ss_oe), .mosi_o(mosi_o), .sh_done(sh_done), .sh_fall(sh_fall),
  .wr_data(wr_data)
);

// File: tb/tb_spi_ctrl.sv
`timescale 1ns/1ps
module tb_spi_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       gie = 1'b1, irq;
  logic       dir_mosi = 1'b1, dir_miso = 1'b1, dir_sck = 1'b1, dir_ss = 1'b0;
  logic       sck_i = 1'b0, sck_o, sck_oe;
  logic       mosi_i = 1'b0, mosi_o, mosi_oe;
  logic       miso_i = 1'b0, miso_o, miso_oe;
  logic       ss_i = 1'b1, ss_oe;

  int checks = 0, failures = 0, sck_edges = 0;

  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  spi_ctrl dut (.*);

  always #5 clk = ~clk;
  always @(posedge sck_o) sck_edges++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    reg_sel = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_sel = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic clear_flag();
    logic [7:0] v;
    reg_read(A_STAT, v);
    reg_read(A_DATA, v);
  endtask

  // bench acts as the slave: returns the byte seen on MOSI and the last SCK half period
  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sl,
                             output logic [7:0] got, output int hp);
    realtime t0, t1;
    miso_i = sl[7];
    reg_write(A_DATA, tx);
    for (int i = 7; i >= 0; i--) begin
      @(posedge sck_o); t0 = $realtime;
      #1 got[i] = mosi_o;
      @(negedge sck_o); t1 = $realtime;
      #1 if (i > 0) miso_i = sl[i-1];
      hp = int'((t1 - t0) / 10.0);
    end
    repeat (3) @(negedge clk);
  endtask

  // bench acts as the master towards the slave block
  task automatic slave_bits(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = 8'h00;
    for (int i = 7; i >= 8 - nbits; i--) begin
      mosi_i = mo[i];
      repeat (6) @(negedge clk);
      mi[i] = miso_o;
      sck_i = 1'b1;
      repeat (6) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    reg_read(A_CTRL, v); chk(v == 8'h00, "R1 ctrl after reset", v, 0);
    reg_read(A_STAT, v); chk(v == 8'h00, "R1 status after reset", v, 0);
    chk({sck_oe, mosi_oe, miso_oe, ss_oe} == 4'b0, "R1 output enables",
        {sck_oe, mosi_oe, miso_oe, ss_oe}, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
  endtask

  task automatic t_master_basic();
    logic [7:0] got, v; int hp;
    reg_write(A_CTRL, 8'hE1);
    master_xfer(8'hA5, 8'h3C, got, hp);
    chk(got == 8'hA5, "R2 MOSI byte MSB first", got, 8'hA5);
    chk(hp == 8, "R3 half period code 1", hp, 8);
    chk(sck_o == 1'b0, "R3 SCK rests low", sck_o, 0);
    reg_read(A_STAT, v); chk(v[7] == 1'b1, "R2 flag after byte", v, 8'h80);
    reg_read(A_DATA, v); chk(v == 8'h3C, "R2 received byte", v, 8'h3C);
    reg_read(A_STAT, v); chk(v == 8'h00, "R6 flag cleared by status+data", v, 0);
  endtask

  task automatic t_dividers();
    logic [7:0] got; int hp;
    reg_write(A_CTRL, 8'hC0);
    master_xfer(8'h5A, 8'h00, got, hp);
    chk(hp == 2, "R3 half period code 0", hp, 2);
    clear_flag();
    reg_write(A_CTRL, 8'hC2);
    master_xfer(8'h01, 8'h00, got, hp);
    chk(hp == 32, "R3 half period code 2", hp, 32);
    clear_flag();
    reg_write(A_CTRL, 8'hC3);
    master_xfer(8'hF0, 8'h00, got, hp);
    chk(hp == 64, "R3 half period code 3", hp, 64);
    chk(got == 8'hF0, "R2 MOSI byte at slowest divider", got, 8'hF0);
    clear_flag();
  endtask

  task automatic t_single_buffer();
    logic [7:0] got; int hp, e0;
    reg_write(A_CTRL, 8'hC1);
    e0 = sck_edges;
    fork
      master_xfer(8'h81, 8'h00, got, hp);
      begin repeat (20) @(negedge clk); reg_write(A_DATA, 8'h7E); end
    join
    repeat (100) @(negedge clk);
    chk(got == 8'h81, "R4 byte on MOSI is the first write", got, 8'h81);
    chk(sck_edges - e0 == 8, "R4 exactly 8 SCK edges", sck_edges - e0, 8);
    clear_flag();
  endtask

  task automatic t_flag_irq();
    logic [7:0] got, v; int hp;
    reg_write(A_CTRL, 8'hE0);
    master_xfer(8'h11, 8'h22, got, hp);
    chk(irq == 1'b1, "R7 irq with flag, ie, gie", irq, 1);
    gie = 1'b0; #1;
    chk(irq == 1'b0, "R7 irq masked by gie", irq, 0);
    gie = 1'b1;
    reg_read(A_DATA, v);
    reg_read(A_STAT, v); chk(v[7] == 1'b1, "R6 data read alone keeps flag", v, 8'h80);
    reg_read(A_DATA, v);
    reg_read(A_STAT, v); chk(v[7] == 1'b0, "R6 flag cleared", v, 0);
    chk(irq == 1'b0, "R7 irq low with flag clear", irq, 0);
  endtask

  task automatic t_master_dirs();
    logic [7:0] v;
    reg_write(A_CTRL, 8'hC1);
    dir_ss = 1'b1; ss_i = 1'b0;
    repeat (10) @(negedge clk);
    reg_read(A_CTRL, v); chk(v[6] == 1'b1, "R8 SS output: master kept", v, 8'hC1);
    reg_read(A_STAT, v); chk(v == 8'h00, "R8 SS output: no flag", v, 0);
    chk({ss_oe, miso_oe, sck_oe, mosi_oe} == 4'b1011, "R8 master enables",
        {ss_oe, miso_oe, sck_oe, mosi_oe}, 4'b1011);
    dir_sck = 1'b0; dir_mosi = 1'b0; #1;
    chk({sck_oe, mosi_oe} == 2'b00, "R8 enables follow dir bits", {sck_oe, mosi_oe}, 0);
    dir_sck = 1'b1; dir_mosi = 1'b1; ss_i = 1'b1; dir_ss = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_mode_fault();
    logic [7:0] v;
    reg_write(A_CTRL, 8'hE1);
    ss_i = 1'b0;
    repeat (5) @(negedge clk);
    reg_read(A_CTRL, v); chk(v == 8'hA1, "R9 master bit cleared", v, 8'hA1);
    reg_read(A_STAT, v); chk(v[7] == 1'b1, "R9 flag set on fault", v, 8'h80);
    chk({sck_oe, mosi_oe} == 2'b00, "R9 SCK/MOSI released", {sck_oe, mosi_oe}, 0);
    chk(irq == 1'b1, "R9 irq on fault", irq, 1);
    ss_i = 1'b1;
    repeat (10) @(negedge clk);
    reg_read(A_CTRL, v); chk(v[6] == 1'b0, "R9 master stays cleared", v, 8'hA1);
    reg_read(A_DATA, v);
    reg_write(A_CTRL, 8'hC1);
    reg_read(A_CTRL, v); chk(v[6] == 1'b1, "R9 master restored by write", v, 8'hC1);
    reg_read(A_STAT, v); chk(v == 8'h00, "R9 flag cleared", v, 0);
  endtask

  task automatic t_slave();
    logic [7:0] mi, v;
    reg_write(A_CTRL, 8'h80);
    reg_write(A_DATA, 8'hC3);
    #1 chk({miso_oe, sck_oe, mosi_oe, ss_oe} == 4'b0, "R10 SS high: all inputs",
           {miso_oe, sck_oe, mosi_oe, ss_oe}, 0);
    ss_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(miso_oe == 1'b1, "R10 MISO driven while selected", miso_oe, 1);
    dir_miso = 1'b0; #1;
    chk(miso_oe == 1'b0, "R10 MISO follows dir bit", miso_oe, 0);
    dir_miso = 1'b1;
    slave_bits(8'h5A, 8, mi);
    chk(mi == 8'hC3, "R11 MISO byte MSB first", mi, 8'hC3);
    reg_read(A_STAT, v); chk(v[7] == 1'b1, "R11 slave flag", v, 8'h80);
    reg_read(A_DATA, v); chk(v == 8'h5A, "R11 slave received byte", v, 8'h5A);
    // two bytes without a read
    slave_bits(8'h11, 8, mi);
    slave_bits(8'h22, 8, mi);
    reg_read(A_DATA, v); chk(v == 8'h22, "R5 second byte overwrites", v, 8'h22);
    clear_flag();
    // partial byte, then deselect
    slave_bits(8'hFF, 3, mi);
    ss_i = 1'b1;
    repeat (6) @(negedge clk);
    ss_i = 1'b0;
    repeat (6) @(negedge clk);
    slave_bits(8'h96, 8, mi);
    reg_read(A_DATA, v); chk(v == 8'h96, "R10 partial bits discarded", v, 8'h96);
    clear_flag();
    // deselected: edges ignored
    ss_i = 1'b1;
    repeat (6) @(negedge clk);
    slave_bits(8'hE7, 8, mi);
    reg_read(A_STAT, v); chk(v == 8'h00, "R10 no flag while deselected", v, 0);
    reg_read(A_DATA, v); chk(v == 8'h96, "R10 buffer unchanged while deselected", v, 8'h96);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_master_basic();
    t_dividers();
    t_single_buffer();
    t_flag_irq();
    t_master_dirs();
    t_mode_fault();
    t_slave();
    finish_run();
  end
endmodule